// File: doc/BRIEF.md
# Flash Erase/Program Suspend Controller

This block is the command decoder and sequencing logic that sits in front of a flash memory's internal write engine. Software writes command bytes, each with an address, one per cycle. The block starts block erases and byte programs. It can pause either operation and continue it later. It also lets a program run while an erase is paused, and that program can itself be paused. The block drives a status byte, an active-low busy pin and a selector for what a read returns (array, status or query data). It also issues single-cycle start, pause and continue strobes to the erase and program timers.

Internal countdown counters stand in for the length of each operation. An erase lasts `ERASE_CYC` active cycles and a program lasts `PROG_CYC` active cycles. Paused time does not count toward either.

Suspension nests at most two levels deep: an erase, then a program inside it. A continue command always resumes the innermost paused operation. A second continue is needed to restart the erase. While an erase is paused, the decoder accepts only a narrow set of commands.

Top module: `flash_susp_ctrl`

## Requirements
- R1: After reset, status reads 0x80, the read selector is array (0), the busy pin is high, all four strobes are low and the configuration is the default.
- R2: Command 0x20 followed by 0xD0 starts an erase on the cycle after the confirm. The address given with the confirm is latched on `op_addr`. `erase_go` pulses for one cycle. Status bit 7 (ready) drops and busy goes low. Ready returns after `ERASE_CYC` active cycles.
- R3: Command 0x40 followed by any byte starts a program at that byte's address. `prog_go` pulses and ready returns after `PROG_CYC` active cycles.
- R4: Command 0xB0 during a running erase or program pulses `op_pause`. It sets ready (bit 7) together with bit 6 (erase paused) or bit 2 (program paused), and releases busy. The remaining time is held.
- R5: While an erase is paused, only these commands are accepted: 0x98, 0x70, 0x50, 0xB8, 0xD0 and 0x40. Any other byte (for example 0x20, 0xFF or 0xB0) leaves the status, the read selector and the strobes unchanged.
- R6: Command 0xD0 at any address resumes the paused operation. It clears bits 7 and 6 (or 7 and 2) on the next cycle, pulses `op_continue`, drives busy low under the default configuration and forces the read selector to status (1).
- R7: A program started inside an erase pause runs with status 0x40. If that program is paused, status is 0xC4. One 0xD0 resumes only the program. When the program ends, status returns to 0xC0 with the erase still paused.
- R8: 0xD0 written while the nested program is running is ignored and does not restart the erase.
- R9: 0xB0 written while the nested program is paused is rejected: there is no third level, status stays 0xC4 and no pause strobe fires.
- R10: If `vpen_hi` is low in any cycle of an erase pause, the resuming 0xD0 sets status bit 3 (voltage error) and abandons the erase. Status then reads 0x88 and no continue strobe fires.
- R11: Command 0x50 clears only the error bits 5 and 3. The ready and pause bits are kept.
- R12: Command 0xB8 loads the busy mode from address bit 0. A value of 1 holds busy high; a value of 0 restores the default level behaviour.
- R13: 0xFF selects array (0), 0x70 selects status (1) and 0x98 selects query (2). Starting an erase or a program forces status.
- R14: An erase setup followed by any byte other than 0xD0 aborts to ready and sets the sequence-error bit 5 (status 0xA0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command byte valid this cycle |
| cmd_addr | input | ADDR_W | Address written with the command |
| cmd_data | input | 8 | Command byte |
| vpen_hi | input | 1 | Programming enable at its high level |
| status | output | 8 | Status byte (7 ready, 6 erase paused, 5 sequence error, 3 voltage error, 2 program paused) |
| busy_n | output | 1 | Low while an operation runs (default mode) |
| rd_mode | output | 2 | Read selector: 0 array, 1 status, 2 query |
| op_addr | output | ADDR_W | Address of the most recently started operation |
| erase_go | output | 1 | Erase timer start strobe |
| prog_go | output | 1 | Program timer start strobe |
| op_pause | output | 1 | Pause strobe to the active timer |
| op_continue | output | 1 | Continue strobe to the paused timer |

## Verification
The properties assume that `cmd_we` carries at most one byte per cycle and that `vpen_hi` changes only while the erase is paused or idle. The stimulus changes `vpen_hi` only in the middle of an erase pause, and it issues every command as a single-cycle write from a task on the falling edge. The timing assertions also assume that no command coincides with the last cycle of a countdown. The stimulus places each suspend well before the end of the operation, so completion never races a command.

// File: rtl/flash_susp_ctrl.sv
module flash_susp_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int ERASE_CYC = 64,
  parameter int PROG_CYC  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              vpen_hi,
  output logic [7:0]        status,
  output logic              busy_n,
  output logic [1:0]        rd_mode,
  output logic [ADDR_W-1:0] op_addr,
  output logic              erase_go,
  output logic              prog_go,
  output logic              op_pause,
  output logic              op_continue
);
  localparam int EW = $clog2(ERASE_CYC + 1);
  localparam int PW = $clog2(PROG_CYC + 1);
  localparam logic [7:0] C_SUSP = 8'hB0, C_GO = 8'hD0, C_ERASE = 8'h20, C_PROG = 8'h40,
                         C_RSTAT = 8'h70, C_CLR = 8'h50, C_QUERY = 8'h98, C_ARRAY = 8'hFF,
                         C_CFG = 8'hB8;
  localparam logic [1:0] M_ARRAY = 2'd0, M_STAT = 2'd1, M_QUERY = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_ESET, S_PSET, S_ERASE, S_PROG, S_PSUSP, S_ESUSP, S_NSET, S_NPROG, S_NSUSP
  } st_t;

  st_t          state;
  logic [EW-1:0] ecnt;
  logic [PW-1:0] pcnt;
  logic          err_v, err_s, cfg_off, vp_drop;

  wire esusp_grp = (state == S_ESUSP) || (state == S_NSET) || (state == S_NPROG) || (state == S_NSUSP);
  wire in_setup  = (state == S_ESET) || (state == S_PSET) || (state == S_NSET);
  wire running   = (state == S_ERASE) || (state == S_PROG) || (state == S_NPROG);
  wire psusp     = (state == S_PSUSP) || (state == S_NSUSP);
  wire is_susp   = cmd_we && (cmd_data == C_SUSP);
  wire is_go     = cmd_we && (cmd_data == C_GO);

  assign status = {~running, esusp_grp, err_s, 1'b0, err_v, psusp, 2'b00};
  assign busy_n = cfg_off | ~running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  ecnt <= '0;  pcnt <= '0;  rd_mode <= M_ARRAY;  op_addr <= '0;
      err_v <= 1'b0;  err_s <= 1'b0;  cfg_off <= 1'b0;  vp_drop <= 1'b0;
      erase_go <= 1'b0;  prog_go <= 1'b0;  op_pause <= 1'b0;  op_continue <= 1'b0;
    end else begin
      erase_go <= 1'b0;  prog_go <= 1'b0;  op_pause <= 1'b0;  op_continue <= 1'b0;
      if (esusp_grp && !vpen_hi) vp_drop <= 1'b1;
      if (cmd_we && !in_setup) begin
        case (cmd_data)
          C_RSTAT: rd_mode <= M_STAT;
          C_QUERY: rd_mode <= M_QUERY;
          C_ARRAY: if (!esusp_grp) rd_mode <= M_ARRAY;
          C_CLR:   begin err_v <= 1'b0; err_s <= 1'b0; end
          C_CFG:   cfg_off <= cmd_addr[0];
          default: ;
        endcase
      end
      case (state)
        S_IDLE:
          if (cmd_we && cmd_data == C_ERASE) state <= S_ESET;
          else if (cmd_we && cmd_data == C_PROG) state <= S_PSET;
        S_ESET:
          if (cmd_we) begin
            rd_mode <= M_STAT;
            if (cmd_data == C_GO) begin
              state <= S_ERASE;  ecnt <= EW'(ERASE_CYC);  erase_go <= 1'b1;  op_addr <= cmd_addr;
            end else begin
              state <= S_IDLE;  err_s <= 1'b1;
            end
          end
        S_PSET, S_NSET:
          if (cmd_we) begin
            state   <= (state == S_NSET) ? S_NPROG : S_PROG;
            pcnt    <= PW'(PROG_CYC);
            prog_go <= 1'b1;
            op_addr <= cmd_addr;
            rd_mode <= M_STAT;
          end
        S_ERASE:
          if (ecnt == EW'(1)) state <= S_IDLE;
          else if (is_susp) begin
            state <= S_ESUSP;  op_pause <= 1'b1;  rd_mode <= M_STAT;  vp_drop <= 1'b0;
          end else ecnt <= ecnt - EW'(1);
        S_PROG, S_NPROG:
          if (pcnt == PW'(1)) state <= (state == S_NPROG) ? S_ESUSP : S_IDLE;
          else if (is_susp) begin
            state <= (state == S_NPROG) ? S_NSUSP : S_PSUSP;  op_pause <= 1'b1;  rd_mode <= M_STAT;
          end else pcnt <= pcnt - PW'(1);
        S_PSUSP, S_NSUSP:
          if (is_go) begin
            state <= (state == S_NSUSP) ? S_NPROG : S_PROG;  op_continue <= 1'b1;  rd_mode <= M_STAT;
          end
        S_ESUSP:
          if (is_go) begin
            rd_mode <= M_STAT;
            if (vp_drop || !vpen_hi) begin
              state <= S_IDLE;  err_v <= 1'b1;
            end else begin
              state <= S_ERASE;  op_continue <= 1'b1;
            end
          end else if (cmd_we && cmd_data == C_PROG) state <= S_NSET;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_go, prog_go, op_pause, op_continue}));  // R2
  AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ESUSP && is_go && vpen_hi && !vp_drop) |=>
      (!status[7] && !status[6] && rd_mode == M_STAT && op_continue));  // R6
  AST_RESUME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ESUSP && is_go && vpen_hi && !vp_drop && !cfg_off) |=> !busy_n);  // R6
  AST_SUSP_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ESUSP && cmd_we && (cmd_data == C_ERASE || cmd_data == C_SUSP)) |=>
      (status == $past(status) && !op_pause));  // R5
  AST_NEST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_NSUSP && is_go) |=> (status[6] && !status[2] && !status[7]));  // R7
  AST_NO_EARLY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_NPROG) |=> (state != S_ERASE && !op_continue));  // R8
  AST_NO_THIRD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_NSUSP && is_susp) |=> (status == 8'hC4 && !op_pause));  // R9
  AST_VPEN_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ESUSP && is_go && (vp_drop || !vpen_hi)) |=> (status[3] && !op_continue));  // R10
endmodule

// File: tb/flash_susp_ctrl_bench.sv
module flash_susp_ctrl_bench;
  localparam int AW = 16, E = 64, P = 16;
  logic clk = 1'b0, rst_n = 1'b0, cmd_we = 1'b0, vpen_hi = 1'b1;
  logic [AW-1:0] cmd_addr = '0, op_addr;
  logic [7:0] cmd_data = '0, status;
  logic busy_n, erase_go, prog_go, op_pause, op_continue;
  logic [1:0] rd_mode;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_susp_ctrl #(.ADDR_W(AW), .ERASE_CYC(E), .PROG_CYC(P)) u_flash_susp_ctrl (
    .clk, .rst_n, .cmd_we, .cmd_addr, .cmd_data, .vpen_hi, .status, .busy_n, .rd_mode,
    .op_addr, .erase_go, .prog_go, .op_pause, .op_continue);

  typedef struct {
    string      req;
    logic [7:0] st;
    logic [1:0] md;
    logic       bn;
    logic [3:0] sb;
  } exp_t;
  exp_t q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input logic [7:0] st, input logic [1:0] md,
                            input logic bn, input logic [3:0] sb);
    exp_t it;
    it.req = req; it.st = st; it.md = md; it.bn = bn; it.sb = sb;
    q.push_back(it);
  endtask

  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      check({it.req, " status"}, {24'd0, status}, {24'd0, it.st});
      check({it.req, " rd_mode"}, {30'd0, rd_mode}, {30'd0, it.md});
      check({it.req, " busy_n"}, {31'd0, busy_n}, {31'd0, it.bn});
      check({it.req, " strobes"}, {28'd0, erase_go, prog_go, op_pause, op_continue}, {28'd0, it.sb});
    end
  end

  task automatic cmd(input logic [7:0] d, input logic [AW-1:0] a = '0);
    @(negedge clk);
    cmd_we = 1'b1; cmd_data = d; cmd_addr = a;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_out("R1 reset", 8'h80, 2'd0, 1'b1, 4'b0000);
    idle(1);

    cmd(8'h98); expect_out("R13 query", 8'h80, 2'd2, 1'b1, 4'b0000);
    cmd(8'h70); expect_out("R13 status", 8'h80, 2'd1, 1'b1, 4'b0000);
    cmd(8'hFF); expect_out("R13 array", 8'h80, 2'd0, 1'b1, 4'b0000);

    cmd(8'h40); expect_out("R3 setup", 8'h80, 2'd0, 1'b1, 4'b0000);
    cmd(8'hA5, 16'h0012); expect_out("R3 start", 8'h00, 2'd1, 1'b0, 4'b0100);
    #1 check("R3 op_addr", {16'd0, op_addr}, 32'h0012);
    idle(P - 1); expect_out("R3 still busy", 8'h00, 2'd1, 1'b0, 4'b0000);
    idle(1); expect_out("R3 done", 8'h80, 2'd1, 1'b1, 4'b0000);

    cmd(8'h20); cmd(8'hFF); expect_out("R14 seq error", 8'hA0, 2'd1, 1'b1, 4'b0000);
    cmd(8'h50); expect_out("R11 clear", 8'h80, 2'd1, 1'b1, 4'b0000);

    cmd(8'hB8, 16'h0001);
    cmd(8'h40); cmd(8'h00); expect_out("R12 busy held high", 8'h00, 2'd1, 1'b1, 4'b0100);
    idle(P); expect_out("R12 done", 8'h80, 2'd1, 1'b1, 4'b0000);
    cmd(8'hB8, 16'h0000);

    cmd(8'h20); cmd(8'hD0, 16'h0300); expect_out("R2 erase start", 8'h00, 2'd1, 1'b0, 4'b1000);
    #1 check("R2 op_addr", {16'd0, op_addr}, 32'h0300);
    idle(10);
    cmd(8'hB0); expect_out("R4 erase suspend", 8'hC0, 2'd1, 1'b1, 4'b0010);
    cmd(8'hFF); expect_out("R5 array ignored", 8'hC0, 2'd1, 1'b1, 4'b0000);
    cmd(8'h20); expect_out("R5 erase ignored", 8'hC0, 2'd1, 1'b1, 4'b0000);
    cmd(8'hB0); expect_out("R5 suspend ignored", 8'hC0, 2'd1, 1'b1, 4'b0000);
    cmd(8'h98); expect_out("R5 query accepted", 8'hC0, 2'd2, 1'b1, 4'b0000);
    cmd(8'h70); expect_out("R5 status accepted", 8'hC0, 2'd1, 1'b1, 4'b0000);
    cmd(8'h50); expect_out("R11 keeps pause bits", 8'hC0, 2'd1, 1'b1, 4'b0000);
    cmd(8'h40); expect_out("R7 nested setup", 8'hC0, 2'd1, 1'b1, 4'b0000);
    cmd(8'h5A, 16'h0044); expect_out("R7 nested run", 8'h40, 2'd1, 1'b0, 4'b0100);
    idle(3);
    cmd(8'hD0); expect_out("R8 resume ignored", 8'h40, 2'd1, 1'b0, 4'b0000);
    cmd(8'hB0); expect_out("R7 nested suspend", 8'hC4, 2'd1, 1'b1, 4'b0010);
    cmd(8'hB0); expect_out("R9 third level", 8'hC4, 2'd1, 1'b1, 4'b0000);
    cmd(8'h98);
    cmd(8'hD0); expect_out("R7 program resume", 8'h40, 2'd1, 1'b0, 4'b0001);
    idle(P - 7); expect_out("R7 program busy", 8'h40, 2'd1, 1'b0, 4'b0000);
    idle(1); expect_out("R7 back to erase pause", 8'hC0, 2'd1, 1'b1, 4'b0000);
    cmd(8'hD0, 16'h7FFF); expect_out("R6 erase resume", 8'h00, 2'd1, 1'b0, 4'b0001);
    idle(E - 12); expect_out("R2 erase busy", 8'h00, 2'd1, 1'b0, 4'b0000);
    idle(1); expect_out("R2 erase done", 8'h80, 2'd1, 1'b1, 4'b0000);

    cmd(8'h20); cmd(8'hD0); idle(2);
    cmd(8'hB0); expect_out("R10 suspend", 8'hC0, 2'd1, 1'b1, 4'b0010);
    vpen_hi = 1'b0; idle(2); vpen_hi = 1'b1;
    cmd(8'hD0); expect_out("R10 voltage error", 8'h88, 2'd1, 1'b1, 4'b0000);
    cmd(8'h50); expect_out("R11 clear verr", 8'h80, 2'd1, 1'b1, 4'b0000);

    cmd(8'h40); cmd(8'h11);
    cmd(8'hB0); expect_out("R4 program suspend", 8'h84, 2'd1, 1'b1, 4'b0010);
    cmd(8'hD0); expect_out("R6 program resume", 8'h00, 2'd1, 1'b0, 4'b0001);
    idle(P - 2); expect_out("R6 program busy", 8'h00, 2'd1, 1'b0, 4'b0000);
    idle(1); expect_out("R6 program done", 8'h80, 2'd1, 1'b1, 4'b0000);
    cmd(8'hFF); expect_out("R13 array again", 8'h80, 2'd0, 1'b1, 4'b0000);

    idle(2);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule